// File: doc/BRIEF.md
# Cascadable Display Column Data Sampler

This block is the digital front end of a display column driver. It waits in standby until it sees a start token on its enable input at a rising clock edge. On each of the following edges it takes three 6-bit grey codes (lanes A, B and C) in parallel and writes them into one triplet slot of a sampling register. A full row is `NUM_TRIPLETS` (default 80) capture edges long. The order in which slots are filled is set by a static direction input, so a panel can be scanned from either side.

One clock before the final triplet is taken, the block raises a one-cycle cascade enable. This output can be wired straight into the enable input of the next device, so a chain of devices fills a wider row with no gap between them. A load strobe copies the whole sampling register into a holding register that drives the column outputs. The next row can therefore be sampled while the current row is on display. High impedance on the column pins is represented by a low output-enable flag, with the data bus forced to zero.

The controller is a three-state machine:
- `ST_STANDBY` waits for the token. Taking `en_in` moves it to `ST_FILL` with the counter at zero.
- `ST_FILL` captures one triplet per edge. It moves on to `ST_FINAL` after capturing word `NUM_TRIPLETS-2`, and raises the cascade output on that same edge.
- `ST_FINAL` captures the last word, drops the cascade output and returns to `ST_STANDBY`.

Top module: `column_sampler`

## Requirements
- R1: When `rst_n` is low at a rising edge, the state goes to standby, the counter clears, and `en_out` and `col_oe` go low. Every sampling and holding slot becomes zero.
- R2: When `en_in` is high at an edge in standby, capture starts on the next edge. Exactly `NUM_TRIPLETS` consecutive edges are captured, and then the block is back in standby. Bus data at edges outside a row changes no slot.
- R3: Triplet slot i, counted from 0, sits at `col_out[18*i +: 18]`. Lane A is in bits 5:0 of that field, lane B in bits 11:6 and lane C in bits 17:12. Each code is plain binary with weights 32, 16, 8, 4, 2, 1 from bit 5 down to bit 0.
- R4: With `dir_up` high, capture k of a row (k from 0) goes into slot k. With `dir_up` low, it goes into slot `NUM_TRIPLETS-1-k`.
- R5: `en_out` goes high at the edge that captures word `NUM_TRIPLETS-2`, is low again after the next edge, and is high for exactly one cycle per row.
- R6: A high `en_in` during a row, including at the edge of the final capture, is ignored. The row length and the `en_out` timing do not change.
- R7: When `load` is high at a rising edge, the holding register takes a copy of the whole sampling register from before that edge.
- R8: `col_oe` is high in the cycle after an edge with `load` high and low otherwise. While `col_oe` is low, `col_out` is all zeros, which stands for the floating outputs.
- R9: When two devices are chained through `en_out` to `en_in`, the second device captures bus words `NUM_TRIPLETS` to `2*NUM_TRIPLETS-1` of an uninterrupted stream, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_in | input | 1 | Start token from the host or the previous device |
| dir_up | input | 1 | Fill order: 1 ascending, 0 descending (static during a row) |
| lane_a | input | 6 | Grey code for the A output of the current triplet |
| lane_b | input | 6 | Grey code for the B output of the current triplet |
| lane_c | input | 6 | Grey code for the C output of the current triplet |
| load | input | 1 | Transfer strobe, sampling register to holding register |
| en_out | output | 1 | Cascade token to the next device |
| col_oe | output | 1 | Column outputs driven (1) or floating (0) |
| col_out | output | 1440 | Held grey codes of all triplets, zero while floating |

## Verification
If the state or the counter goes wrong, it shows up first on `en_out`. A row that is one edge short or long moves the cascade pulse by a cycle, or splits it, and this is visible within the same row. In a chain, the error then shows up in the second device's slots one row length later. A wrong write index or fill order appears only after the next load, as triplets in the wrong slots of `col_out`. Each row is therefore followed by a load and a full slot-by-slot comparison.

// File: rtl/col_pkg.sv
package col_pkg;

    // Controller states of the row sampler
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_FILL    = 2'd1,
        ST_FINAL   = 2'd2
    } col_state_t;

    localparam int LANES = 3;

endpackage

// File: rtl/col_seq_ctrl.sv
module col_seq_ctrl
    import col_pkg::*;
#(
    parameter int NUM_TRIPLETS = 80,
    parameter int IDX_W        = $clog2(NUM_TRIPLETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             dir_up,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             en_out
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRIPLETS - 1);
    localparam logic [IDX_W-1:0] PREV_IDX = IDX_W'(NUM_TRIPLETS - 2);

    col_state_t       state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STANDBY: begin
                cnt_d = '0;
                if (en_in) state_d = ST_FILL;
            end
            ST_FILL: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == PREV_IDX) state_d = ST_FINAL;
            end
            ST_FINAL: begin
                cnt_d   = '0;
                state_d = ST_STANDBY;
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_STANDBY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered cascade output
    always_ff @(posedge clk) begin
        if (!rst_n) en_out <= 1'b0;
        else        en_out <= (state_q == ST_FILL) && (cnt_q == PREV_IDX);
    end

    assign wr_en  = (state_q != ST_STANDBY);
    assign wr_idx = dir_up ? cnt_q : (LAST_IDX - cnt_q);

    // R5
    cascade_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_out |=> !en_out);
    // R5
    cascade_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_out |-> state_q == ST_FINAL);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
    // R6
    fill_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cnt_q != PREV_IDX) |=>
            (state_q == ST_FILL && cnt_q == $past(cnt_q) + 1'b1));
    // R2
    final_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINAL) |=> (state_q == ST_STANDBY));

endmodule

// File: rtl/col_sample_bank.sv
module col_sample_bank #(
    parameter int NUM_TRIPLETS = 80,
    parameter int SLOT_W       = 18,
    parameter int IDX_W        = $clog2(NUM_TRIPLETS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [SLOT_W-1:0]              wr_data,
    output logic [NUM_TRIPLETS*SLOT_W-1:0] samp_flat
);

    logic [SLOT_W-1:0] slot_q [NUM_TRIPLETS];

    for (genvar i = 0; i < NUM_TRIPLETS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                slot_q[i] <= wr_data;
        end
        assign samp_flat[i*SLOT_W +: SLOT_W] = slot_q[i];
    end

    // R4
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> samp_flat[$past(wr_idx)*SLOT_W +: SLOT_W] == $past(wr_data));
    // R2
    slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(samp_flat));

endmodule

// File: rtl/col_hold_bank.sv
module col_hold_bank #(
    parameter int TOTAL_W = 1440
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TOTAL_W-1:0] samp_flat,
    output logic               col_oe,
    output logic [TOTAL_W-1:0] col_out
);

    logic [TOTAL_W-1:0] hold_q;
    logic               oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= load;
            if (load) hold_q <= samp_flat;
        end
    end

    assign col_oe  = oe_q;
    assign col_out = oe_q ? hold_q : '0;

    // R7
    hold_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> col_out == $past(samp_flat));
    // R8
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !col_oe);

endmodule

// File: rtl/column_sampler.sv
module column_sampler
    import col_pkg::*;
#(
    parameter int NUM_TRIPLETS = 80,
    parameter int CODE_W       = 6,
    localparam int SLOT_W      = LANES * CODE_W,
    localparam int TOTAL_W     = NUM_TRIPLETS * SLOT_W,
    localparam int IDX_W       = $clog2(NUM_TRIPLETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_in,
    input  logic               dir_up,
    input  logic [CODE_W-1:0]  lane_a,
    input  logic [CODE_W-1:0]  lane_b,
    input  logic [CODE_W-1:0]  lane_c,
    input  logic               load,
    output logic               en_out,
    output logic               col_oe,
    output logic [TOTAL_W-1:0] col_out
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TOTAL_W-1:0] samp_flat;

    col_seq_ctrl #(
        .NUM_TRIPLETS (NUM_TRIPLETS),
        .IDX_W        (IDX_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (en_in),
        .dir_up (dir_up),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .en_out (en_out)
    );

    col_sample_bank #(
        .NUM_TRIPLETS (NUM_TRIPLETS),
        .SLOT_W       (SLOT_W),
        .IDX_W        (IDX_W)
    ) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   ({lane_c, lane_b, lane_a}),
        .samp_flat (samp_flat)
    );

    col_hold_bank #(
        .TOTAL_W (TOTAL_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .samp_flat (samp_flat),
        .col_oe    (col_oe),
        .col_out   (col_out)
    );

    // R8
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> col_oe);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!en_out && !col_oe));

endmodule

// File: tb/column_sampler_bench.sv
module column_sampler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 80;
    localparam int SW         = 18;
    localparam int TW         = N * SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0;
    logic dir_up = 1'b1;
    logic load = 1'b0;
    logic [5:0] lane_a = '0, lane_b = '0, lane_c = '0;
    logic en_out1, en_out2, oe1, oe2;
    logic [TW-1:0] out1, out2;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [SW-1:0] exp1 [N];
    logic [SW-1:0] exp2 [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    column_sampler u_column_sampler (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .dir_up(dir_up),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .load(load),
        .en_out(en_out1), .col_oe(oe1), .col_out(out1));

    column_sampler u_column_sampler_next (
        .clk(clk), .rst_n(rst_n), .en_in(en_out1), .dir_up(dir_up),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .load(load),
        .en_out(en_out2), .col_oe(oe2), .col_out(out2));

    function automatic int slot_of(input int k, input logic up);
        return up ? k : (N - 1 - k);
    endfunction

    function automatic logic [SW-1:0] word_for(input int mode, input int k);
        logic [5:0] a, b, c;
        if (mode == 0) begin
            a = 6'($urandom); b = 6'($urandom); c = 6'($urandom);
        end else begin
            a = 6'(k); b = 6'(63 - (k % 64)); c = (k % 2) ? 6'h3F : 6'h00;
        end
        return {c, b, a};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end");
            finish_run();
        end
    end

    // Runs a chained row of 2N words, with optional ignored enable pulses (R6)
    task automatic run_row(input int mode, input bit pulses);
        int hi1 = 0, hi2 = 0;
        logic [SW-1:0] w;
        @(negedge clk);
        en_in = 1'b1;
        for (int k = 0; k < 2 * N; k++) begin
            @(negedge clk);
            en_in = (pulses && (k == 30 || k == N - 1)) ? 1'b1 : 1'b0;
            w = word_for(mode, k);
            {lane_c, lane_b, lane_a} = w;
            if (k < N) exp1[slot_of(k, dir_up)] = w;
            else       exp2[slot_of(k - N, dir_up)] = w;
            if (en_out1) hi1++;
            if (en_out2) hi2++;
            // R5 cascade pulse follows the edge capturing word N-2
            chk(en_out1 == (k == N - 1), "R5 dev1 en_out timing", en_out1, k == N - 1);
            // R9 second device hands off one row later
            chk(en_out2 == (k == 2 * N - 1), "R9 dev2 en_out timing", en_out2, k == 2 * N - 1);
        end
        // extra words outside any row must be dropped (R2)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            en_in = 1'b0;
            {lane_c, lane_b, lane_a} = word_for(0, k);
            if (en_out2) hi2++;
        end
        chk(hi1 == 1, "R5 dev1 single pulse", hi1, 1);
        chk(hi2 == 1, "R9 dev2 single pulse", hi2, 1);
    endtask

    task automatic load_and_check(input string tag);
        int bad1 = 0, bad2 = 0;
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(oe1 && oe2, "R8 oe after load", {oe1, oe2}, 2'b11);
        for (int i = 0; i < N; i++) begin
            if (out1[i*SW +: SW] !== exp1[i]) begin
                bad1++;
                chk(1'b0, {"R7 R4 dev1 slot ", tag}, out1[i*SW +: SW], exp1[i]);
            end
            if (out2[i*SW +: SW] !== exp2[i]) begin
                bad2++;
                chk(1'b0, {"R9 dev2 slot ", tag}, out2[i*SW +: SW], exp2[i]);
            end
        end
        chk(bad1 == 0, "R3 dev1 row image", bad1, 0);
        chk(bad2 == 0, "R9 dev2 row image", bad2, 0);
        @(negedge clk);
        chk(!oe1 && out1 == '0, "R8 float after load low", oe1, 0);
        chk(!oe2 && out2 == '0, "R8 dev2 float", oe2, 0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        for (int i = 0; i < N; i++) begin
            exp1[i] = '0;
            exp2[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!en_out1 && !oe1 && out1 == '0, "R1 reset outputs", {en_out1, oe1}, 0);
        rst_n = 1'b1;
        // R1 cleared sampling register seen through a load
        load_and_check("reset");

        dir_up = 1'b1;
        run_row(1, 1'b0);              // R3 ramp, ascending
        load_and_check("ramp up");

        dir_up = 1'b0;
        run_row(0, 1'b0);              // R4 descending
        load_and_check("rand down");

        dir_up = 1'b1;
        run_row(0, 1'b1);              // R6 pulses mid-row and at final edge
        load_and_check("pulses");

        // R1 reset in the middle of a row
        @(negedge clk);
        en_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            en_in = 1'b0;
            {lane_c, lane_b, lane_a} = word_for(0, k);
        end
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!en_out1 && !oe1, "R1 mid-row reset", en_out1, 0);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            exp1[i] = '0;
            exp2[i] = '0;
        end
        dir_up = 1'b0;
        run_row(1, 1'b1);
        load_and_check("after reset");

        for (int r = 0; r < 4; r++) begin
            dir_up = r[0];
            run_row(0, r[1]);          // R2 R4 random rows
            load_and_check("random");
        end
        finish_run();
    end

endmodule